// File: doc/BRIEF.md
# Lane-Masked Simple Dual-Port RAM

This block is a simple dual-port memory: one port only writes, the other only reads, and each runs on its own clock. The write side always takes 18-bit words. It stores them as two 9-bit lanes, and each lane has its own write-enable bit, so a caller can update one half of a word and leave the other half untouched. The read side returns a registered value one read-clock edge after the address is presented. Its width is fixed at elaboration to one of 18, 9, 4, 2 or 1 bits.

A narrow read uses extra low address bits to pick a slice of the stored word. The 9-bit width always returns the upper lane. The read output register has its own clock enable. It is cleared by an active-low read reset, which a parameter makes either synchronous or asynchronous. The memory contents are not affected by that reset.

Top module: `sdp_lane_ram`

## Requirements
- R1: A write happens on a rising edge of `wclk_i` when `wr_ce_i` is high. Bit 0 of `wr_be_i` stores `wr_data_i[8:0]` and bit 1 stores `wr_data_i[17:9]` at word `wr_addr_i`. A lane whose bit is low keeps its old contents.
- R2: With `wr_ce_i` low, or with `wr_be_i` equal to 2'b00, the memory is unchanged.
- R3: With `RD_W`=18, `rd_addr_i` is a word address and the read returns the full 18-bit word.
- R4: With `RD_W`=9, `rd_addr_i` is a word address and the read returns bits 17..9 of that word.
- R5: With `RD_W` of 4, 2 or 1, `rd_addr_i` = {word, k}, where k has log2(16/`RD_W`) bits. The slice k starts at bit (k's top bit)*9 + (k's remaining bits)*`RD_W`. Bits 8 and 17 cannot be read at these widths.
- R6: When `rd_ce_i` is high at a rising edge of `rclk_i`, `rd_data_o` takes the addressed value after that edge. When `rd_ce_i` is low, `rd_data_o` holds its value.
- R7: When a read and a write hit the same word on one shared clock edge, the read returns the contents from before the write.
- R8: With `ASYNC_RST`=0, `rst_ni` low clears `rd_data_o` at the next `rclk_i` edge, even when `rd_ce_i` is low. Before that edge the output is unchanged. The memory contents survive the reset.
- R9: With `ASYNC_RST`=1, `rd_data_o` goes to zero as soon as `rst_ni` falls, without waiting for a clock edge.
- R10: After reset, `rd_data_o` is zero and stays zero until the first enabled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| wr_ce_i | input | 1 | Write clock enable |
| wr_be_i | input | 2 | Lane write enables (bit0 low lane, bit1 high lane) |
| wr_addr_i | input | AW | Write word address |
| wr_data_i | input | 18 | Write data |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low read output reset |
| rd_ce_i | input | 1 | Read clock enable |
| rd_addr_i | input | AW+log2 slice count | Read address, word bits above slice bits |
| rd_data_o | output | RD_W | Registered read data |

## Verification
The hardest case to create is a read and a write to the same word on the same edge. To produce it, the bench drives both ports from one clock and presents the colliding addresses together in a single cycle. The reset timing is also hard to observe. The bench drops `rst_ni` between two clock edges while the outputs hold nonzero data. It then looks immediately and again after the next edge, which separates the asynchronous instance from the synchronous ones. Three instances with read widths 18, 9 and 4 share one write stream, so every slice of every word in a 16-word memory is swept against a reference array.

// File: rtl/sdp_ram_pkg.sv
package sdp_ram_pkg;
  localparam int LANE_W    = 9;
  localparam int LANES     = 2;
  localparam int WORD_W    = LANE_W * LANES;
  localparam int LANE_DATA = 8;  // usable bits per lane at narrow widths

  // extra read address bits needed to pick a slice
  function automatic int sel_bits(input int rd_w);
    case (rd_w)
      1:       return 4;
      2:       return 3;
      4:       return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sdp_lane_store.sv
module sdp_lane_store #(
  parameter int AW = 10,
  parameter int W  = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  p_lane_write_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
  p_no_write_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !we_i |=> mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]));
endmodule

// File: rtl/sdp_slice_mux.sv
module sdp_slice_mux
  import sdp_ram_pkg::*;
#(
  parameter int RD_W = 4,
  parameter int SB   = 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SB-1:0]     sel_i,
  output logic [RD_W-1:0]   data_o
);
  logic unused_parity;
  assign unused_parity = word_i[LANE_W-1] ^ word_i[WORD_W-1];

  // top select bit picks the lane, the rest the slice inside its 8 data bits
  always_comb begin
    int base;
    base   = int'(sel_i[SB-1]) * LANE_W + int'(sel_i[SB-2:0]) * RD_W;
    data_o = word_i[base +: RD_W];
  end
endmodule

// File: rtl/sdp_rd_reg.sv
module sdp_rd_reg #(
  parameter int W     = 18,
  parameter bit ASYNC = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (ASYNC) begin : g_async
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (en_i) q_o <= d_i;
    end
    always @(posedge clk_i) begin
      if (!rst_ni) p_async_clr_r9: assert (q_o == '0);
    end
  end else begin : g_sync
    // reset not gated by the enable
    always_ff @(posedge clk_i) begin
      if (!rst_ni)   q_o <= '0;
      else if (en_i) q_o <= d_i;
    end
    p_sync_clr_r8: assert property (@(posedge clk_i)
      !rst_ni |=> q_o == '0);
  end

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o == $past(d_i));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/sdp_lane_ram.sv
module sdp_lane_ram
  import sdp_ram_pkg::*;
#(
  parameter int AW        = 10,
  parameter int RD_W      = 18,
  parameter bit ASYNC_RST = 1'b0,
  localparam int SB  = sel_bits(RD_W),
  localparam int RAW = AW + SB
) (
  input  logic              wclk_i,
  input  logic              wr_ce_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              rd_ce_i,
  input  logic [RAW-1:0]    rd_addr_i,
  output logic [RD_W-1:0]   rd_data_o
);
  logic [AW-1:0]     rd_word_addr;
  logic [WORD_W-1:0] rd_word;
  logic [RD_W-1:0]   rd_pick;

  assign rd_word_addr = rd_addr_i[RAW-1 -: AW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdp_lane_store #(.AW(AW), .W(LANE_W)) u_store (
      .wclk_i (wclk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_ce_i & wr_be_i[g]),
      .waddr_i(wr_addr_i),
      .wdata_i(wr_data_i[g*LANE_W +: LANE_W]),
      .raddr_i(rd_word_addr),
      .rdata_o(rd_word[g*LANE_W +: LANE_W])
    );
  end

  if (RD_W == WORD_W) begin : g_full
    assign rd_pick = rd_word;
  end else if (RD_W == LANE_W) begin : g_half
    logic unused_low;
    assign unused_low = ^rd_word[LANE_W-1:0];
    assign rd_pick    = rd_word[WORD_W-1 -: LANE_W];
  end else begin : g_narrow
    sdp_slice_mux #(.RD_W(RD_W), .SB(SB)) u_mux (
      .word_i(rd_word),
      .sel_i (rd_addr_i[SB-1:0]),
      .data_o(rd_pick)
    );
  end

  sdp_rd_reg #(.W(RD_W), .ASYNC(ASYNC_RST)) u_rd_reg (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .en_i  (rd_ce_i),
    .d_i   (rd_pick),
    .q_o   (rd_data_o)
  );
endmodule

// File: tb/sdp_lane_ram_tb.sv
`timescale 1ns/1ps
module sdp_lane_ram_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_ce = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [3:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_ce = 1'b0;
  logic [3:0]  ra = '0;
  logic [5:0]  ra4 = '0;
  logic [17:0] q18;
  logic [8:0]  q9;
  logic [3:0]  q4;
  logic [17:0] ref_mem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdp_lane_ram #(.AW(AW), .RD_W(18), .ASYNC_RST(1'b0)) dut_i (
    .wclk_i(clk), .wr_ce_i(wr_ce), .wr_be_i(wr_be), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rclk_i(clk), .rst_ni(rst_n), .rd_ce_i(rd_ce),
    .rd_addr_i(ra), .rd_data_o(q18));
  sdp_lane_ram #(.AW(AW), .RD_W(9), .ASYNC_RST(1'b1)) dut9_i (
    .wclk_i(clk), .wr_ce_i(wr_ce), .wr_be_i(wr_be), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rclk_i(clk), .rst_ni(rst_n), .rd_ce_i(rd_ce),
    .rd_addr_i(ra), .rd_data_o(q9));
  sdp_lane_ram #(.AW(AW), .RD_W(4), .ASYNC_RST(1'b0)) dut4_i (
    .wclk_i(clk), .wr_ce_i(wr_ce), .wr_be_i(wr_be), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rclk_i(clk), .rst_ni(rst_n), .rd_ce_i(rd_ce),
    .rd_addr_i(ra4), .rd_data_o(q4));

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp4(input logic [5:0] a);
    logic [17:0] w;
    int base;
    w = ref_mem[a[5:2]];
    base = int'(a[1]) * 9 + int'(a[0]) * 4;
    return w[base +: 4];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [17:0] d,
                    input logic [1:0] be, input logic ce);
    @(negedge clk);
    wr_ce = ce; wr_be = be; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_ce = 1'b0;
    if (ce) begin
      if (be[0]) ref_mem[a][8:0]  = d[8:0];
      if (be[1]) ref_mem[a][17:9] = d[17:9];
    end
  endtask

  // one enabled read; outputs checked one edge later
  task automatic rd(input logic [3:0] a, input logic [1:0] k);
    @(negedge clk);
    rd_ce = 1'b1; ra = a; ra4 = {a, k};
    @(negedge clk);
    rd_ce = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 reset q18", q18, '0);
    chk("R10 reset q9", {9'd0, q9}, '0);
    chk("R10 reset q4", {14'd0, q4}, '0);
    rst_n = 1'b1;
    ra = 4'd3; ra4 = 6'd13;
    repeat (2) @(negedge clk);
    chk("R10 idle after reset", q18, '0);

    // lane behaviour on word 0
    wr(4'd0, 18'h3ffff, 2'b11, 1'b1);
    wr(4'd0, 18'h00000, 2'b01, 1'b1);
    rd(4'd0, 2'd0);
    chk("R1 low lane only", q18, 18'h3fe00);
    wr(4'd0, 18'h00000, 2'b10, 1'b1);
    rd(4'd0, 2'd0);
    chk("R1 high lane only", q18, 18'h00000);
    wr(4'd0, 18'h3ffff, 2'b00, 1'b1);
    rd(4'd0, 2'd0);
    chk("R2 mask 00", q18, 18'h00000);
    wr(4'd0, 18'h3ffff, 2'b11, 1'b0);
    rd(4'd0, 2'd0);
    chk("R2 ce low", q18, 18'h00000);

    // fill, then lane-masked overwrite pass
    for (int i = 0; i < DEPTH; i++)
      wr(4'(i), 18'(i * 18'h1b3d5 + 18'h0a5a5), 2'b11, 1'b1);
    for (int i = 0; i < DEPTH; i++)
      wr(4'(i), ~18'(i * 18'h2c6f1 + 18'h13579), 2'(i % 4), 1'b1);

    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < 4; k++) begin
        rd(4'(a), 2'(k));
        if (k == 0) begin
          chk("R3 full word", q18, ref_mem[a]);
          chk("R4 upper lane", {9'd0, q9}, {9'd0, ref_mem[a][17:9]});
        end
        chk("R5 slice", {14'd0, q4}, {14'd0, exp4({4'(a), 2'(k)})});
      end
    end

    // hold with enable low
    rd(4'd7, 2'd1);
    @(negedge clk); ra = 4'd2; ra4 = 6'd9;
    @(negedge clk);
    chk("R6 hold q18", q18, ref_mem[7]);
    chk("R6 hold q4", {14'd0, q4}, {14'd0, exp4({4'd7, 2'd1})});

    // read and write to the same word on one edge
    @(negedge clk);
    rd_ce = 1'b1; ra = 4'd5; ra4 = {4'd5, 2'd2};
    wr_ce = 1'b1; wr_be = 2'b11; wr_addr = 4'd5; wr_data = 18'h2db6d;
    @(negedge clk);
    rd_ce = 1'b0; wr_ce = 1'b0;
    chk("R7 old word", q18, ref_mem[5]);
    chk("R7 old upper", {9'd0, q9}, {9'd0, ref_mem[5][17:9]});
    ref_mem[5] = 18'h2db6d;
    rd(4'd5, 2'd2);
    chk("R7 new word after", q18, 18'h2db6d);

    // reset dropped between edges
    #5 rst_n = 1'b0;
    #1;
    chk("R9 async clears at once", {9'd0, q9}, '0);
    chk("R8 sync waits for edge", q18, 18'h2db6d);
    @(negedge clk);
    chk("R8 sync cleared q18", q18, '0);
    chk("R8 sync cleared q4", {14'd0, q4}, '0);
    rst_n = 1'b1;
    rd(4'd5, 2'd2);
    chk("R8 memory kept", q18, 18'h2db6d);
    chk("R8 memory kept slice", {14'd0, q4}, {14'd0, exp4({4'd5, 2'd2})});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule